// File: doc/BRIEF.md
# Serial Long-Integer Multiply-Accumulate Coprocessor

The block is a coprocessor that a host drives through a small word-wide register port. It evaluates the long product-sum P = S + A·B one 32-bit result word at a time. A is a 512-bit multiplicand made of sixteen 32-bit digits and held constant for a whole run. B and S are streams of 32-bit words of any length. The access address and the access direction select one of four commands: load a digit of A, load the B word, issue a step with an S word, or fetch a result word.

A step issued with an S word adds that word, weighted by 2^512, to a wide accumulator, together with A times the buffered B word. The low 32 bits become the result word for the step, and the accumulator then moves down by one word. The multiply is bit-serial over the B word and takes 32 clocks per step. While a step runs, `busy_o` is high. Loads of A and B and result fetches may overlap a running step, and they only affect later steps. Because of the 2^512 weighting, an S word first reaches the output sixteen steps after the step that carried it, on the 17th result.

Top module: `serial_bigmul`

## Requirements
- R1: Commands are decoded from `req_addr_i` while `req_valid_i` is high. A write to address 0 loads an A digit, a write to address 1 loads B, a write to address 2 issues a step, and a read (`req_write_i` low) from address 3 fetches a result. Writes to address 3 and reads from addresses 0 to 2 change no state and no output.
- R2: Each A load shifts the new digit in at the most significant end of a sixteen-digit staging register. After sixteen loads, the first digit written is the least significant digit of A.
- R3: Only a step command starts a computation. `busy_o` rises on the clock after an accepted step and stays high for exactly 32 clocks.
- R4: A step with S word s forms T = P + s·2^512 + A·B. The result word is T mod 2^32, and the new accumulator P is T div 2^32. The result word replaces the previous one at the clock on which `busy_o` falls.
- R5: A step command issued while `busy_o` is high is ignored and leaves both the result stream and the busy timing unchanged.
- R6: A and B loads made while a step runs do not disturb it. A staged A becomes active when the next step is accepted, and B is captured at that moment.
- R7: A result fetch updates `rdata_o` on the next clock with the word of the most recently completed step, even while a step is running. At all other times `rdata_o` holds its value.
- R8: The B buffer is not consumed by a step, so consecutive steps reuse the last B written.
- R9: With P = 0 and B = 0, an S word issued in one step appears as the 17th result word counted from that step, and the 16 results before it are zero.
- R10: After B is loaded with 0, 17 steps with S = 0 empty the accumulator, so a further step with B = 0 and S = 0 returns 0.
- R11: After reset, the accumulator, buffers, result word and `rdata_o` are zero and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access strobe, one clock per command |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_addr_i | input | 2 | Command address |
| req_wdata_i | input | 32 | Write data: A digit, B word or S word |
| rdata_o | output | 32 | Result word returned by the last fetch |
| busy_o | output | 1 | Step in progress; step commands are ignored while high |

## Verification
An accepted step raises `busy_o` one clock later and finishes 32 clocks after that. Its result word can be fetched only after `busy_o` has fallen, and a fetch lands in `rdata_o` one clock after the fetch access. The bench drives on falling edges. It waits for `busy_o` to be low before each step and compares a fetch on the falling edge right after the fetch clock. Fetches and loads that overlap a step are timed inside the 32-clock busy window, and they are compared against the word of the step before. The S latency is checked by counting result words: it is a step count, not a clock count.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    CMD_LOAD_A = 2'd0,
    CMD_LOAD_B = 2'd1,
    CMD_STEP   = 2'd2,
    CMD_FETCH  = 2'd3
  } sbm_cmd_e;
endpackage

// File: rtl/sbm_decode.sv
module sbm_decode
  import sbm_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [1:0] addr_i,
  input  logic       busy_i,
  output logic       load_a_o,
  output logic       load_b_o,
  output logic       start_o,
  output logic       fetch_o
);
  sbm_cmd_e cmd;
  assign cmd = sbm_cmd_e'(addr_i);

  always_comb begin
    load_a_o = 1'b0;
    load_b_o = 1'b0;
    start_o  = 1'b0;
    fetch_o  = 1'b0;
    if (valid_i) begin
      unique case (cmd)
        CMD_LOAD_A: load_a_o = write_i;
        CMD_LOAD_B: load_b_o = write_i;
        CMD_STEP:   start_o  = write_i & ~busy_i;
        CMD_FETCH:  fetch_o  = ~write_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbm_operand.sv
module sbm_operand #(
  parameter int WORD_W = 32,
  parameter int DIGITS = 16,
  localparam int A_W   = WORD_W * DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] digit_i,
  output logic [A_W-1:0]    a_o
);
  logic [WORD_W-1:0] stage_q [DIGITS];
  logic [A_W-1:0]    stage_flat;
  logic [A_W-1:0]    active_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    if (g == DIGITS - 1) begin : g_top
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)     stage_q[g] <= '0;
        else if (load_i) stage_q[g] <= digit_i;
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)     stage_q[g] <= '0;
        else if (load_i) stage_q[g] <= stage_q[g+1];
    end
    assign stage_flat[g*WORD_W +: WORD_W] = stage_q[g];
  end

  // active copy is frozen while a step runs
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       active_q <= '0;
    else if (commit_i) active_q <= stage_flat;

  assign a_o = active_q;
endmodule

// File: rtl/sbm_core.sv
module sbm_core #(
  parameter int WORD_W = 32,
  parameter int DIGITS = 16,
  localparam int A_W   = WORD_W * DIGITS,
  localparam int ACC_W = A_W + WORD_W + 1,
  localparam int HI_W  = ACC_W - A_W,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] s_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [A_W-1:0]    a_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] pout_o
);
  logic [ACC_W-1:0]  acc_q;
  logic [WORD_W-1:0] b_work_q;
  logic [WORD_W-1:0] out_sr_q;
  logic [WORD_W-1:0] pout_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  logic [ACC_W:0]    sum;
  logic [HI_W-1:0]   hi_sum;
  logic [WORD_W-1:0] out_next;
  logic              last_bit;

  assign sum      = {1'b0, acc_q} + {{(HI_W + 1){1'b0}}, (b_work_q[0] ? a_i : '0)};
  assign hi_sum   = acc_q[ACC_W-1:A_W] + {1'b0, s_i};
  assign out_next = {sum[0], out_sr_q[WORD_W-1:1]};
  assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      b_work_q <= '0;
      out_sr_q <= '0;
      pout_q   <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
    end else if (start_i) begin
      // fold S in at weight 2^A_W, capture B
      acc_q    <= {hi_sum, acc_q[A_W-1:0]};
      b_work_q <= b_i;
      cnt_q    <= '0;
      busy_q   <= 1'b1;
    end else if (busy_q) begin
      acc_q    <= sum[ACC_W:1];
      b_work_q <= b_work_q >> 1;
      out_sr_q <= out_next;
      cnt_q    <= cnt_q + 1'b1;
      if (last_bit) begin
        pout_q <= out_next;
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign pout_o = pout_q;
endmodule

// File: rtl/serial_bigmul.sv
module serial_bigmul #(
  parameter int WORD_W   = 32,
  parameter int A_DIGITS = 16,
  localparam int A_W     = WORD_W * A_DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              busy_o
);
  logic              load_a, load_b, start, fetch;
  logic [WORD_W-1:0] b_buf_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] pout;
  logic [A_W-1:0]    a_act;

  sbm_decode u_dec (
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .busy_i   (busy_o),
    .load_a_o (load_a),
    .load_b_o (load_b),
    .start_o  (start),
    .fetch_o  (fetch)
  );

  sbm_operand #(.WORD_W(WORD_W), .DIGITS(A_DIGITS)) u_opa (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_a),
    .commit_i (start),
    .digit_i  (req_wdata_i),
    .a_o      (a_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     b_buf_q <= '0;
    else if (load_b) b_buf_q <= req_wdata_i;

  sbm_core #(.WORD_W(WORD_W), .DIGITS(A_DIGITS)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .s_i     (req_wdata_i),
    .b_i     (b_buf_q),
    .a_i     (a_act),
    .busy_o  (busy_o),
    .pout_o  (pout)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    rdata_q <= '0;
    else if (fetch) rdata_q <= pout;

  assign rdata_o = rdata_q;
endmodule

// File: rtl/serial_bigmul_chk.sv
module serial_bigmul_chk #(
  parameter int WORD_W = 32,
  parameter int A_W    = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [1:0]        req_addr_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              busy_o,
  input logic [WORD_W-1:0] pout,
  input logic [A_W-1:0]    a_act
);
  logic [7:0] run_cnt_q;
  logic       fetch_req, step_req;

  assign fetch_req = req_valid_i && !req_write_i && (req_addr_i == 2'd3);
  assign step_req  = req_valid_i && req_write_i && (req_addr_i == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     run_cnt_q <= '0;
    else if (busy_o) run_cnt_q <= run_cnt_q + 1'b1;
    else             run_cnt_q <= '0;

  AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_cnt_q == 8'(WORD_W))); // R3
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(step_req)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(pout)); // R4
  AST_A_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(a_act)); // R6
  AST_FETCH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req |=> (rdata_o == $past(pout))); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req |=> $stable(rdata_o)); // R7
endmodule

bind serial_bigmul serial_bigmul_chk #(.WORD_W(WORD_W), .A_W(A_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .rdata_o     (rdata_o),
  .busy_o      (busy_o),
  .pout        (pout),
  .a_act       (a_act)
);

// File: tb/serial_bigmul_bench.sv
module serial_bigmul_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] rdata_o;
  logic        busy_o;

  int n_checks = 0;
  int n_fail = 0;

  logic [511:0] a_stg_m = '0;
  logic [31:0]  b_m = '0;
  logic [544:0] p_m = '0;
  logic [31:0]  last_m = '0;
  logic [31:0]  prev_m = '0;

  always #2 clk = ~clk;

  serial_bigmul u_serial_bigmul (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rdata_o     (rdata_o),
    .busy_o      (busy_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] addr, input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = we; req_addr_i = addr; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic load_a(input logic [31:0] d);
    access(1'b1, 2'd0, d);
    a_stg_m = {d, a_stg_m[511:32]};
  endtask

  task automatic load_b(input logic [31:0] d);
    access(1'b1, 2'd1, d);
    b_m = d;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  // issues a step from idle and updates the model
  task automatic step(input logic [31:0] s);
    logic [544:0] t;
    wait_idle();
    access(1'b1, 2'd2, s);
    t = p_m + ({513'b0, s} << 512) + ({33'b0, a_stg_m} * {513'b0, b_m});
    prev_m = last_m;
    last_m = t[31:0];
    p_m = t >> 32;
    check(busy_o === 1'b1, "R3 busy after step", {31'b0, busy_o}, 32'd1);
  endtask

  task automatic fetch_chk(input logic [31:0] exp, input string req);
    access(1'b0, 2'd3, 32'h0);
    check(rdata_o === exp, req, rdata_o, exp);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] r;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(rdata_o === 32'h0 && busy_o === 1'b0, "R11 reset", rdata_o, 32'h0);
    fetch_chk(32'h0, "R11 reset fetch");

    // R9 latency: A=0, B=0, S pulse appears at 17th result
    step(32'hCAFE0001);
    wait_idle(); fetch_chk(32'h0, "R9 first result zero");
    for (int i = 0; i < 15; i++) step(32'h0);
    wait_idle(); fetch_chk(32'h0, "R9 16th result zero");
    step(32'h0);
    wait_idle(); fetch_chk(32'hCAFE0001, "R9 17th result");

    // R2 digit order: first digit loaded is least significant
    load_a(32'h1);
    for (int i = 0; i < 15; i++) load_a(32'h0);
    load_b(32'h5);
    step(32'h0);
    wait_idle(); fetch_chk(32'h5, "R2 digit order");

    // R3 busy span
    step(32'h0);
    cyc = 0;
    while (busy_o) begin cyc++; @(negedge clk); end
    check(cyc == 32, "R3 busy span", cyc, 32);
    fetch_chk(last_m, "R8 B reused");

    // R1 ignored accesses: write to addr 3, reads from addr 0..2
    r = rdata_o;
    access(1'b1, 2'd3, 32'hFFFF_FFFF);
    check(busy_o === 1'b0, "R1 write addr3 no step", {31'b0, busy_o}, 32'd0);
    access(1'b0, 2'd0, 32'h0);
    access(1'b0, 2'd1, 32'h0);
    access(1'b0, 2'd2, 32'h0);
    check(rdata_o === r, "R1 reads 0..2 ignored", rdata_o, r);
    step(32'h0);
    wait_idle(); fetch_chk(last_m, "R1 state untouched");

    // R5 step while busy ignored
    step(32'h1111_2222);
    access(1'b1, 2'd2, 32'h7777_7777);
    cyc = 2;
    while (busy_o) begin cyc++; @(negedge clk); end
    check(cyc == 32, "R5 busy span unchanged", cyc, 32);
    fetch_chk(last_m, "R5 ignored step");
    for (int i = 0; i < 17; i++) begin
      step(32'h0);
      wait_idle();
    end
    fetch_chk(last_m, "R5 stream unchanged");

    // random run: R4, R6, R7, R8
    for (int i = 0; i < 16; i++) load_a($urandom);
    load_b($urandom);
    for (int k = 0; k < 200; k++) begin
      step($urandom);
      if ($urandom_range(0, 1) == 1) begin
        access(1'b0, 2'd3, 32'h0);
        check(rdata_o === prev_m, "R7 fetch during step", rdata_o, prev_m);
      end
      if ($urandom_range(0, 2) == 0) load_b($urandom);
      if ($urandom_range(0, 3) == 0) load_a($urandom);
      wait_idle();
      fetch_chk(last_m, "R4 R6 R8 result word");
    end

    // R10 flush
    load_b(32'h0);
    for (int i = 0; i < 17; i++) step(32'h0);
    check(p_m == '0, "R10 model empty", p_m[31:0], 32'h0);
    step(32'h0);
    wait_idle(); fetch_chk(32'h0, "R10 flushed");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule